// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one read or write command for a two-bank synchronous graphics memory into the column addresses of its burst, one address per clock. It keeps a small mode register that holds the burst length, the burst ordering and the read latency. When a command arrives, the block copies those settings for that burst, so that a later mode change cannot affect the burst already running.

Each issued column comes out with its bank bit and direction. A read-data-valid strobe follows every read column after exactly the programmed latency, and a done flag marks the end of a burst. The block follows fixed-length bursts, and full-page bursts that run until a stop command ends them. A new command accepted on any clock replaces the burst in progress at once. All inputs are sampled on the rising edge of `clk`, and every output comes from a register.

Top module: `burst_col_seq`

## Requirements
- R1: Synchronous active-high `rst` clears `col_valid`, `burst_done` and `rd_valid`, and loads the mode register with burst length code 3 (8 columns), sequential order (`mode_ord`=0) and latency 2.
- R2: A command (`cmd_valid`=1) sampled on an edge makes `col_valid` high in the next cycle, with `col_addr` equal to `cmd_col` and with `col_bank`/`col_write` equal to `cmd_bank`/`cmd_write`. Commands on consecutive clocks are each accepted.
- R3: Burst length code 0, 1, 2 or 3 issues 1, 2, 4 or 8 columns on consecutive clocks. Codes 4 to 7 select a full-page burst.
- R4: In sequential order (`mode_ord`=0), a burst of length L counts the low log2(L) column bits upward from the start column and wraps inside the L-aligned block. The upper column bits keep their start value.
- R5: In interleaved order (`mode_ord`=1), the k-th column of a fixed-length burst (k from 0) has its low log2(L) bits equal to the start column's low bits XOR k. The upper bits keep their start value.
- R6: A full-page burst ignores `mode_ord`. It increments from the start column, wraps from column 2^COL_W-1 to 0, and continues without end until stopped or replaced.
- R7: `burst_done` is high in the same cycle as the last column of a fixed-length burst, and it is low during that burst's other columns.
- R8: `stop` sampled while a burst is active, with no command on the same edge, leaves `col_valid` low and makes `burst_done` high in the next cycle. `stop` while idle changes no output.
- R9: A command accepted during a burst cuts that burst off. The next cycle shows the new start column, and the cut-off burst never raises `burst_done`. When a command and `stop` arrive on the same edge, the command wins.
- R10: `rd_valid` is high exactly CL cycles after each cycle in which `col_valid`=1 and `col_write`=0, where CL is the latency code 1, 2 or 3 (code 0 means 1) that was in force when the burst started. Write columns never produce `rd_valid`.
- R11: `mode_wr` loads the mode register on the edge. A command on that same edge uses the previous settings, and a burst keeps the settings it started with until it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Load the mode register |
| mode_bl | input | 3 | Burst length code: 0..3 give 1/2/4/8 columns, 4..7 give full page |
| mode_ord | input | 1 | Burst order: 0 sequential, 1 interleaved |
| mode_cl | input | CL_W | Read latency code (0 treated as 1) |
| cmd_valid | input | 1 | Start a burst this cycle |
| cmd_write | input | 1 | Command direction: 1 write, 0 read |
| cmd_bank | input | 1 | Bank select of the command |
| cmd_col | input | COL_W | Start column |
| stop | input | 1 | Terminate the active burst |
| col_valid | output | 1 | A column is issued this cycle |
| col_bank | output | 1 | Bank of the issued column |
| col_write | output | 1 | Direction of the issued column |
| col_addr | output | COL_W | Issued column address |
| burst_done | output | 1 | Burst ended (last column or stop) |
| rd_valid | output | 1 | Read data valid, CL cycles after a read column |

## Verification
Two kinds of event can fall on the same clock. The first is a new command arriving on the edge where the running burst would issue its last column, or together with a stop. The second is a read column being inserted into the latency pipeline while the strobe of an earlier burst with a different latency is still travelling. The bench provokes the first case by issuing commands two cycles into a burst, back to back, and together with `stop`. It provokes the second by switching the latency between closely spaced read bursts. A behavioural model built on integer arithmetic and a per-cycle table of due strobes predicts every output, and the bench compares those predictions with the outputs on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned BL_W = 3;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  function automatic logic bl_full(input logic [BL_W-1:0] code);
    return code[BL_W-1];
  endfunction

endpackage

// File: rtl/bsq_mode_reg.sv
module bsq_mode_reg
  import burst_seq_pkg::*;
#(
  parameter int unsigned MAX_CL = 3,
  parameter int unsigned CL_W   = 2,
  parameter int unsigned DEF_BL = 3,
  parameter int unsigned DEF_CL = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [BL_W-1:0] bl_in,
  input  logic            ord_in,
  input  logic [CL_W-1:0] cl_in,
  output logic [BL_W-1:0] cfg_bl,
  output order_e          cfg_ord,
  output logic [CL_W-1:0] cfg_cl
);

  logic [CL_W-1:0] cl_fix;

  always_comb begin
    if (cl_in == '0)
      cl_fix = CL_W'(1);
    else if (int'(cl_in) > MAX_CL)
      cl_fix = CL_W'(MAX_CL);
    else
      cl_fix = cl_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_bl  <= BL_W'(DEF_BL);
      cfg_ord <= ORD_LINEAR;
      cfg_cl  <= CL_W'(DEF_CL);
    end else if (wr) begin
      cfg_bl  <= bl_in;
      cfg_ord <= order_e'(ord_in);
      cfg_cl  <= cl_fix;
    end
  end

  a_r10_cl_legal: assert property (@(posedge clk) disable iff (rst)
    (cfg_cl != '0) && (int'(cfg_cl) <= MAX_CL));

endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] idx,
  input  logic [BL_W-1:0]  bl,
  input  order_e           ord,
  output logic [COL_W-1:0] blk_mask,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] lin_sum;
  logic [COL_W-1:0] xor_val;

  always_comb begin
    if (bl_full(bl)) begin
      blk_mask = '1;
    end else begin
      case (bl[1:0])
        2'd0:    blk_mask = COL_W'(0);
        2'd1:    blk_mask = COL_W'(1);
        2'd2:    blk_mask = COL_W'(3);
        default: blk_mask = COL_W'(7);
      endcase
    end
  end

  assign lin_sum = start + idx;
  assign xor_val = start ^ idx;

  always_comb begin
    if (bl_full(bl))
      addr = lin_sum;
    else if (ord == ORD_XOR)
      addr = (start & ~blk_mask) | (xor_val & blk_mask);
    else
      addr = (start & ~blk_mask) | (lin_sum & blk_mask);
  end

endmodule

// File: rtl/bsq_rd_pipe.sv
module bsq_rd_pipe #(
  parameter int unsigned MAX_CL = 3,
  parameter int unsigned CL_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins,
  input  logic [CL_W-1:0] cl,
  output logic            rd_valid
);

  logic [MAX_CL:1] stage;

  for (genvar j = 1; j <= MAX_CL; j++) begin : g_stage
    logic hit;
    assign hit = ins && (cl == CL_W'(MAX_CL - j + 1));
    if (j == 1) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stage[j] <= 1'b0;
        else     stage[j] <= hit;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stage[j] <= 1'b0;
        else     stage[j] <= stage[j-1] | hit;
      end
    end
  end

  assign rd_valid = stage[MAX_CL];

  a_r10_ins_cl_range: assert property (@(posedge clk) disable iff (rst)
    ins |-> (cl != '0) && (int'(cl) <= MAX_CL));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned MAX_CL = 3,
  parameter int unsigned DEF_BL = 3,
  parameter int unsigned DEF_CL = 2,
  localparam int unsigned CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [2:0]       mode_bl,
  input  logic             mode_ord,
  input  logic [CL_W-1:0]  mode_cl,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             cmd_bank,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             stop,
  output logic             col_valid,
  output logic             col_bank,
  output logic             col_write,
  output logic [COL_W-1:0] col_addr,
  output logic             burst_done,
  output logic             rd_valid
);

  logic [BL_W-1:0]  cfg_bl;
  order_e           cfg_ord;
  logic [CL_W-1:0]  cfg_cl;

  logic             active;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] idx_q;
  logic [BL_W-1:0]  bl_q;
  order_e           ord_q;
  logic [CL_W-1:0]  cl_q;

  logic [COL_W-1:0] blk_mask;
  logic [COL_W-1:0] next_addr;
  logic             at_last;
  logic             first_last;

  bsq_mode_reg #(
    .MAX_CL (MAX_CL),
    .CL_W   (CL_W),
    .DEF_BL (DEF_BL),
    .DEF_CL (DEF_CL)
  ) u_mode (
    .clk    (clk),
    .rst    (rst),
    .wr     (mode_wr),
    .bl_in  (mode_bl),
    .ord_in (mode_ord),
    .cl_in  (mode_cl),
    .cfg_bl (cfg_bl),
    .cfg_ord(cfg_ord),
    .cfg_cl (cfg_cl)
  );

  bsq_addr_gen #(
    .COL_W (COL_W)
  ) u_addr (
    .start   (start_q),
    .idx     (idx_q),
    .bl      (bl_q),
    .ord     (ord_q),
    .blk_mask(blk_mask),
    .addr    (next_addr)
  );

  assign at_last    = !bl_full(bl_q) && (idx_q == blk_mask);
  assign first_last = (cfg_bl == BL_W'(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      col_valid  <= 1'b0;
      col_bank   <= 1'b0;
      col_write  <= 1'b0;
      col_addr   <= '0;
      burst_done <= 1'b0;
      start_q    <= '0;
      idx_q      <= '0;
      bl_q       <= '0;
      ord_q      <= ORD_LINEAR;
      cl_q       <= CL_W'(1);
    end else if (cmd_valid) begin
      col_valid  <= 1'b1;
      col_addr   <= cmd_col;
      col_bank   <= cmd_bank;
      col_write  <= cmd_write;
      start_q    <= cmd_col;
      idx_q      <= COL_W'(1);
      bl_q       <= cfg_bl;
      ord_q      <= cfg_ord;
      cl_q       <= cfg_cl;
      burst_done <= first_last;
      active     <= !first_last;
    end else if (active && stop) begin
      col_valid  <= 1'b0;
      burst_done <= 1'b1;
      active     <= 1'b0;
    end else if (active) begin
      col_valid  <= 1'b1;
      col_addr   <= next_addr;
      burst_done <= at_last;
      active     <= !at_last;
      idx_q      <= idx_q + COL_W'(1);
    end else begin
      col_valid  <= 1'b0;
      burst_done <= 1'b0;
    end
  end

  bsq_rd_pipe #(
    .MAX_CL (MAX_CL),
    .CL_W   (CL_W)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .ins     (col_valid && !col_write),
    .cl      (cl_q),
    .rd_valid(rd_valid)
  );

  a_r2_first_col: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> col_valid && (col_addr == $past(cmd_col)) && (col_bank == $past(cmd_bank)));

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (active && stop && !cmd_valid) |=> !col_valid && burst_done);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!active && !cmd_valid) |=> !col_valid && !burst_done);

  a_r7_bare_done_is_stop: assert property (@(posedge clk) disable iff (rst)
    (burst_done && !col_valid) |-> $past(stop));

  a_r10_cl1_strobe: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_write && cl_q == CL_W'(1)) |=> rd_valid);

  a_r10_cl2_strobe: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !col_write && cl_q == CL_W'(2)) |=> ##1 rd_valid);

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

  localparam int COL_W = 8;
  localparam int ROW   = 1 << COL_W;
  localparam int CL_W  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 1'b0;
  logic [2:0] mode_bl = 3'd0;
  logic mode_ord = 1'b0;
  logic [CL_W-1:0] mode_cl = '0;
  logic cmd_valid = 1'b0;
  logic cmd_write = 1'b0;
  logic cmd_bank = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic stop = 1'b0;
  logic col_valid, col_bank, col_write, burst_done, rd_valid;
  logic [COL_W-1:0] col_addr;

  always #4 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_bl(mode_bl),
    .mode_ord(mode_ord), .mode_cl(mode_cl), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .stop(stop), .col_valid(col_valid), .col_bank(col_bank),
    .col_write(col_write), .col_addr(col_addr),
    .burst_done(burst_done), .rd_valid(rd_valid)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  bit m_act;
  int m_cnt, m_start, m_len, m_cl;
  bit m_bank, m_wr, m_ord;
  int md_bl, md_cl;
  bit md_ord;
  bit e_cv, e_bank, e_wr, e_done;
  int e_addr;
  bit exp_rd [0:8191];

  function automatic int ref_addr(int s, int c, int len, bit ord);
    int base, off;
    if (len == 0) return (s + c) % ROW;
    base = (s / len) * len;
    off  = s % len;
    if (ord) return base + (off ^ c);
    return base + ((off + c) % len);
  endfunction

  task automatic model_step();
    int n = cyc + 1;
    if (rst) begin
      m_act = 0; e_cv = 0; e_done = 0;
      md_bl = 3; md_ord = 0; md_cl = 2;
      return;
    end
    if (cmd_valid) begin
      m_start = cmd_col; m_bank = cmd_bank; m_wr = cmd_write;
      m_len = (md_bl < 4) ? (1 << md_bl) : 0;
      m_ord = md_ord; m_cl = md_cl;
      e_cv = 1; e_addr = cmd_col; e_bank = cmd_bank; e_wr = cmd_write;
      e_done = (m_len == 1);
      m_act = !e_done; m_cnt = 1;
    end else if (m_act && stop) begin
      e_cv = 0; e_done = 1; m_act = 0;
    end else if (m_act) begin
      e_cv = 1;
      e_addr = ref_addr(m_start, m_cnt, m_len, m_ord);
      e_done = (m_len != 0) && (m_cnt == m_len - 1);
      m_act = !e_done;
      m_cnt = (m_cnt + 1) % ROW;
    end else begin
      e_cv = 0; e_done = 0;
    end
    if (e_cv && !e_wr) exp_rd[n + m_cl] = 1'b1;
    if (mode_wr) begin
      md_bl = int'(mode_bl); md_ord = mode_ord;
      md_cl = (mode_cl == 0) ? 1 : int'(mode_cl);
    end
  endtask

  task automatic check_bit(string what, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d %s got %0b expected %0b", cur_req, cyc, what, got, exp);
    end
  endtask

  task automatic compare();
    check_bit("col_valid", col_valid, e_cv);
    if (e_cv) begin
      checks++;
      if (col_addr !== COL_W'(e_addr) || col_bank !== e_bank || col_write !== e_wr) begin
        errors++;
        $display("FAIL %s cycle %0d col addr/bank/wr got %h/%0b/%0b expected %h/%0b/%0b",
                 cur_req, cyc, col_addr, col_bank, col_write, e_addr[COL_W-1:0], e_bank, e_wr);
      end
    end
    check_bit("burst_done", burst_done, e_done);
    check_bit("rd_valid", rd_valid, rst ? 1'b0 : exp_rd[cyc]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_mode(int bl, bit ord, int cl);
    mode_wr = 1; mode_bl = 3'(bl); mode_ord = ord; mode_cl = CL_W'(cl);
    tick();
    mode_wr = 0;
  endtask

  task automatic issue(bit wr, bit bank, int col);
    cmd_valid = 1; cmd_write = wr; cmd_bank = bank; cmd_col = COL_W'(col);
    tick();
    cmd_valid = 0;
  endtask

  task automatic do_stop();
    stop = 1;
    tick();
    stop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8192; i++) exp_rd[i] = 1'b0;
    @(negedge clk);
    // R1: reset state and default mode
    cur_req = "R1";
    idle(3);
    rst = 0;
    idle(2);
    issue(0, 1, 'h15);
    idle(10);

    // R3 / R4 / R7: every fixed length, sequential
    for (int bl = 0; bl < 4; bl++) begin
      cur_req = "R3";
      set_mode(bl, 0, 1);
      cur_req = "R4";
      issue(0, bl[0], 'h2D);
      cur_req = "R7";
      idle(9);
    end

    // R5: interleaved order
    cur_req = "R5";
    for (int bl = 1; bl < 4; bl++) begin
      set_mode(bl, 1, 1);
      issue(0, 0, 'h6B);
      idle(9);
      issue(1, 1, 'hC6);
      idle(9);
    end

    // R10: latencies 1..3, code 0, writes give no strobe, latency changes
    cur_req = "R10";
    for (int cl = 0; cl < 4; cl++) begin
      set_mode(2, 0, cl);
      issue(0, 0, 'h81 + cl);
      idle(7);
    end
    set_mode(1, 0, 3);
    issue(0, 0, 'h10);
    set_mode(1, 0, 1);
    issue(0, 1, 'h20);
    idle(1);
    issue(1, 0, 'h30);
    issue(0, 0, 'h40);
    idle(6);

    // R6: full page, wraps at row end, order ignored, stop
    cur_req = "R6";
    set_mode(7, 0, 2);
    issue(0, 0, 'hFA);
    idle(12);
    cur_req = "R8";
    do_stop();
    idle(4);
    cur_req = "R6";
    set_mode(4, 1, 1);
    issue(1, 1, 'hFD);
    idle(6);
    do_stop();
    idle(3);

    // R8: stop while idle, stop mid fixed burst, stop on last column
    cur_req = "R8";
    do_stop();
    idle(2);
    set_mode(3, 0, 2);
    issue(0, 0, 'h55);
    idle(2);
    do_stop();
    idle(4);
    issue(0, 0, 'h58);
    idle(6);
    do_stop();
    idle(4);

    // R9: interrupt mid burst, command with stop, back-to-back commands
    cur_req = "R9";
    issue(0, 0, 'h40);
    idle(2);
    issue(0, 1, 'h83);
    idle(2);
    stop = 1;
    issue(1, 0, 'h11);
    stop = 0;
    idle(10);
    issue(0, 0, 'h47);
    idle(6);
    issue(0, 1, 'h90);
    idle(9);
    cur_req = "R2";
    issue(0, 0, 'h01);
    issue(1, 1, 'h02);
    issue(0, 1, 'hF3);
    issue(0, 0, 'h7C);
    idle(10);

    // R11: mode write on the command edge and during a burst
    cur_req = "R11";
    set_mode(3, 0, 2);
    mode_wr = 1; mode_bl = 3'd0; mode_ord = 1'b1; mode_cl = CL_W'(3);
    issue(0, 0, 'h33);
    mode_wr = 0;
    idle(2);
    set_mode(1, 0, 1);
    idle(8);
    issue(0, 1, 'h35);
    idle(6);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule